// File: doc/BRIEF.md
# Watchdog Reset Timer

This block supervises the software of a small microcontroller. A free-running prescaler divides the system clock and steps a 7-bit down-counter. The counter shares one 8-bit register with a sticky enable flag. Software reads the register and writes it to refresh the counter. If software stops refreshing, the counter leaves its upper half while the watchdog is enabled, and the block drives a timed active-low reset pulse.

Two other events also start the pulse. Software can request a reset directly with a register write. A halt request that arrives while the watchdog is enabled causes a reset instead of a halt. A hardware option pin can hold the watchdog enabled at all times. While its own pulse is low, the block returns its counter and enable flag to their reset values. The prescaler keeps its phase through that pulse, so the time to the first decrement after a refresh varies by up to one prescaler period.

Top module: `wdt_reset_timer`

## Requirements
- R1: After the system reset is released, `rd_data` reads `{hw_enable, 7'h7F}` and `wdt_rst_n` is high.
- R2: The counter field decrements by one once every 2^PRESC_BITS clock cycles, whether or not the watchdog is enabled. When disabled, it wraps from 0x00 to 0x7F.
- R3: `rd_data[7]` is the effective enable and `rd_data[6:0]` is the counter. A write loads `wr_data[6:0]` into the counter on that clock edge, and the write wins over a decrement due in the same cycle.
- R4: A write with bit 7 set sets the enable flag. A write with bit 7 clear leaves the flag unchanged. Only a reset clears it.
- R5: When the effective enable is set and a decrement takes the counter from 0x40 to 0x3F, a reset pulse is triggered.
- R6: A write triggers a reset pulse when `wr_data[6]` is 0 and either `wr_data[7]` is 1 or the watchdog is already enabled. Any other write triggers nothing.
- R7: A `halt_req` while the effective enable is set triggers a reset pulse. While the watchdog is disabled, `halt_req` has no effect.
- R8: `wdt_rst_n` goes low on the clock edge that follows a trigger and stays low for exactly PULSE_CYCLES cycles. Triggers that occur while it is low are ignored.
- R9: From the trigger edge until the pulse ends, the enable flag and counter are held at their reset values (reading `{hw_enable, 7'h7F}`). The prescaler phase is not disturbed.
- R10: While `hw_enable` is 1, the watchdog behaves as enabled (R5, R7) and `rd_data[7]` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value: bit 7 enable, bits 6:0 counter |
| halt_req | input | 1 | One-cycle halt request strobe |
| hw_enable | input | 1 | Hardware option forcing the watchdog enabled |
| rd_data | output | 8 | Register read value: bit 7 effective enable, bits 6:0 counter |
| wdt_rst_n | output | 1 | Active-low generated reset pulse |

## Verification
A register write shows up on `rd_data` one edge after the strobe. A decrement shows up one edge after the prescaler's last phase. Every trigger (expiry, write or halt) pulls `wdt_rst_n` low on the very next edge, and the pulse releases PULSE_CYCLES edges later. The bench predicts all of these with a behavioural model that updates on the rising edge. Inputs are driven shortly after the rising edge, and both outputs are compared on the falling edge of every cycle, so each result is checked in the exact cycle it becomes due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 7;
  localparam int REG_W = CNT_W + 1;
  typedef logic [CNT_W-1:0] wdt_cnt_t;
  localparam wdt_cnt_t CNT_RESET  = '1;
  localparam wdt_cnt_t CNT_EXPIRE = wdt_cnt_t'(1 << (CNT_W - 1));
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESC_BITS = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [PRESC_BITS-1:0] presc_q, presc_d;

  always_comb begin
    presc_d = presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  assign tick_o = &presc_q;

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (presc_q == '0 && !tick_o)); // R2
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             tick_i,
  input  logic             hw_en_i,
  output logic             en_eff_o,
  output wdt_cnt_t         cnt_o
);
  logic     en_q, en_d;
  wdt_cnt_t cnt_q, cnt_d;

  always_comb begin
    en_d  = en_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      en_d  = 1'b0;
      cnt_d = CNT_RESET;
    end else if (wr_en_i) begin
      en_d  = en_q | wr_data_i[REG_W-1];
      cnt_d = wr_data_i[CNT_W-1:0];
    end else if (tick_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= CNT_RESET;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  assign en_eff_o = en_q | hw_en_i;
  assign cnt_o    = cnt_q;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clear_i) |=> (cnt_q == $past(wr_data_i[CNT_W-1:0]))); // R3
  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !clear_i) |=> en_q); // R4
  AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!en_q && cnt_q == CNT_RESET)); // R9
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYCLES);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (left_q != '0)  left_d = left_q - 1'b1;
    else if (trig_i)   left_d = PULSE_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign active_o = (left_q != '0);

  AST_TRIG_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !active_o) |=> active_o); // R8
endmodule

// File: rtl/wdt_reset_timer.sv
module wdt_reset_timer
  import wdt_pkg::*;
#(
  parameter int PRESC_BITS   = 14,
  parameter int PULSE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             halt_req,
  input  logic             hw_enable,
  output logic [REG_W-1:0] rd_data,
  output logic             wdt_rst_n
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;
  logic                   tick, en_eff, pulse_active, trig, clear;
  logic                   expire_hit, sw_hit, halt_hit;
  wdt_cnt_t               cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  wdt_prescaler #(.PRESC_BITS(PRESC_BITS)) u_presc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  wdt_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear_i   (clear),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .tick_i    (tick),
    .hw_en_i   (hw_enable),
    .en_eff_o  (en_eff),
    .cnt_o     (cnt)
  );

  wdt_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_i   (trig),
    .active_o (pulse_active)
  );

  always_comb begin
    expire_hit = en_eff & tick & ~wr_en & (cnt == CNT_EXPIRE);
    sw_hit     = wr_en & (en_eff | wr_data[REG_W-1]) & ~wr_data[CNT_W-1];
    halt_hit   = halt_req & en_eff;
    trig       = ~pulse_active & (expire_hit | sw_hit | halt_hit);
    clear      = pulse_active | trig;
  end

  assign rd_data   = {en_eff, cnt};
  assign wdt_rst_n = ~pulse_active;

  AST_EXPIRY_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_eff && tick && !wr_en && cnt == CNT_EXPIRE) |=> !wdt_rst_n); // R5
  AST_HALT_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_req && en_eff) |=> !wdt_rst_n); // R7
  AST_HW_FORCES_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hw_enable |-> rd_data[REG_W-1]); // R10
endmodule

// File: tb/tb_wdt_reset_timer.sv
`timescale 1ns/100ps
module tb_wdt_reset_timer;
  localparam int PB    = 4;
  localparam int PULSE = 8;
  localparam int PMAX  = (1 << PB) - 1;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, halt_req, hw_enable;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       wdt_rst_n;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_sync = 0, m_presc = 0, m_cnt = 127, m_pulse = 0;
  bit m_en = 0;

  always #2.5 clk = ~clk;

  wdt_reset_timer #(.PRESC_BITS(PB), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .halt_req(halt_req), .hw_enable(hw_enable),
    .rd_data(rd_data), .wdt_rst_n(wdt_rst_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_presc = 0; m_cnt = 127; m_pulse = 0; m_en = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      bit eff, tk, trg, busy;
      eff  = m_en | hw_enable;
      tk   = (m_presc == PMAX);
      busy = (m_pulse > 0);
      trg  = !busy && ((wr_en && (eff || wr_data[7]) && !wr_data[6]) ||
                       (halt_req && eff) ||
                       (!wr_en && tk && eff && m_cnt == 64));
      if (trg || busy) begin
        m_en = 0; m_cnt = 127;
      end else if (wr_en) begin
        m_en = m_en | wr_data[7]; m_cnt = wr_data[6:0];
      end else if (tk) begin
        m_cnt = (m_cnt + 127) % 128;
      end
      if (busy) m_pulse = m_pulse - 1;
      else if (trg) m_pulse = PULSE;
      m_presc = (m_presc + 1) % (PMAX + 1);
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    logic       exp_rst;
    cycles++;
    if (rst_n) begin
      exp_rd  = {m_en | hw_enable, 7'(m_cnt)};
      exp_rst = (m_pulse == 0);
      vectors++;
      if (rd_data !== exp_rd || wdt_rst_n !== exp_rst) begin
        errors++;
        $display("FAIL %s: rd_data=%h wdt_rst_n=%b expected rd_data=%h wdt_rst_n=%b at cycle %0d",
                 cur_req, rd_data, wdt_rst_n, exp_rd, exp_rst, cycles);
      end
    end
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 200000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic halt_pulse();
    @(posedge clk); #1; halt_req = 1'b1;
    @(posedge clk); #1; halt_req = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 1'b0;
    idle(3); rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; halt_req = 1'b0; hw_enable = 1'b0;
    idle(3); rst_n = 1'b1;
    cur_req = "R1"; idle(10);
    cur_req = "R2"; idle(2100);                 // full wrap while disabled
    cur_req = "R3"; wr(8'h55); idle(40); wr(8'h12); idle(5);
    for (int k = 0; k < 20; k++) begin wr(8'h70 + 8'(k)); idle(k); end
    cur_req = "R6"; wr(8'h20); idle(20);        // disabled, bit6 clear: no reset
    cur_req = "R7"; halt_pulse(); idle(20);     // disabled: no effect
    cur_req = "R4"; wr(8'hFF); idle(30); wr(8'h7F); idle(30);
    cur_req = "R5"; idle(1100);                 // expiry from upper half
    cur_req = "R9"; idle(40);
    cur_req = "R5"; wr(8'hC5);
    for (int k = 0; k < 10; k++) begin idle(60); wr(8'hC5); end
    wr(8'hC1); idle(120);                        // short timeout expires
    cur_req = "R6"; wr(8'hFF); idle(10); wr(8'hBF); idle(2);
    cur_req = "R8"; wr(8'h80); halt_pulse(); idle(20);
    cur_req = "R6"; wr(8'h80); idle(20);
    cur_req = "R7"; wr(8'hE0); idle(7); halt_pulse(); idle(20);
    cur_req = "R6"; wr(8'hF0); idle(5); wr(8'h05); idle(20); // enabled, bit6 clear
    cur_req = "R10"; hw_enable = 1'b1; do_reset(); idle(1200);
    halt_pulse(); idle(20);
    hw_enable = 1'b0; idle(5);
    cur_req = "R1"; wr(8'hC8); idle(3); do_reset(); idle(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule